// File: doc/BRIEF.md
# Serial Command Port Sequencer

This block is a register-programmed engine that delivers a short list of command bytes to the configuration port of a one-time-programmable memory macro. Software first loads a command buffer, a command count and a target device address. It then writes a single enable bit. The engine presents the buffered bytes one after another on a valid/ready output stream toward the macro port. When the last byte has been accepted, it raises a done flag in a shared interrupt status register.

All control registers take masked half-word writes. The upper 16 bits of the written word select which of the lower 16 bits change. Because of this, software can update the device address, the count or the enable bit without a read-modify-write. A typical use is a two-byte sequence that switches error correction on or off: byte 0xFA (write command 0xC0 combined with register 0x3A) followed by a data byte of 0x00 (on) or 0x09 (off), sent to device address 0x02.

The output stream follows standard valid/ready rules. A byte moves on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_ready` is low, the engine holds `cmd_valid`, `cmd_data`, `cmd_dev` and `cmd_last` steady. The macro may apply back-pressure for any number of cycles.

Top module: `otp_cmd_seq`

## Requirements
- R1: After reset, all register reads return 0, and `cmd_valid` is low.
- R2: Register writes are masked. Bit n of a register changes only when bit n+16 of the written word is 1. The device address sits in control register (0x020) bits 15:8, under mask bits 31:24. The command count sits in the low bits of register 0x024.
- R3: Command word i is written at byte address 0x1000 + 4*i. Only its low 8 bits are kept, and a read at the same address returns them zero-extended.
- R4: Writing 0x00010001 to register 0x020 while idle starts a sequence. `cmd_valid` is high on the cycle after the write edge. Buffer words 0 to count are sent in order, which is count+1 bytes in total. `cmd_dev` carries the address field captured at start, and `cmd_last` marks the final byte.
- R5: While `cmd_ready` is low, `cmd_valid` stays high and `cmd_data`, `cmd_dev` and `cmd_last` hold their values.
- R6: On the edge that accepts the final byte, the sequence ends. From then on, `cmd_valid` is low, status bit 0 (0x02C, busy) and control bit 0 (enable) read 0, and interrupt status bit 1 (0x304) reads 1.
- R7: Writing a word with bit 1 set to 0x304 clears the done flag. Writing a word with bit 1 clear leaves the flag unchanged.
- R8: A new enable write while a sequence is running is ignored. The running sequence neither restarts nor repeats.
- R9: An enable write whose mask bit 16 is 0 (for example 0x00000001) starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data: mask in bits 31:16, value in bits 15:0 |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cmd_valid | output | 1 | A command byte is presented to the macro port |
| cmd_ready | input | 1 | The macro port accepts the byte on this edge |
| cmd_data | output | 8 | Command byte |
| cmd_dev | output | 8 | Target device address |
| cmd_last | output | 1 | The presented byte is the final one of the sequence |

## Verification
An enable write that lands on edge E makes `cmd_valid` high right after E. With `cmd_ready` held high, byte k moves at edge E+1+k. Busy and enable drop, and the done flag rises, right after the edge that moves the last byte, so a sequence with count c finishes c+1 cycles after E. The bench drives inputs and samples outputs on falling edges, and counts falling edges from the write to place each check on its due cycle. It does not poll for these results. Register reads are combinational, so a read returns on the same falling edge the address is applied. A result that must not happen (a restart or a start without its mask bit) is checked at the ports over several cycles after the stimulus.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  localparam logic [15:0] OFS_CTRL   = 16'h0020;
  localparam logic [15:0] OFS_COUNT  = 16'h0024;
  localparam logic [15:0] OFS_STATUS = 16'h002C;
  localparam logic [15:0] OFS_IRQ    = 16'h0304;
  localparam logic [3:0]  BUF_PAGE   = 4'h1;

  // masked half-word update: upper half of w selects which lower bits change
  function automatic logic [15:0] masked_upd(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction
endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import otp_seq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  input  logic             seq_done,
  output logic [7:0]       dev_addr,
  output logic [IDX_W-1:0] cmd_count,
  output logic             start_req,
  output logic             done_q
);
  logic        hit_ctrl, hit_count, hit_irq;
  logic [15:0] ctrl_next, count_next;

  assign hit_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign hit_count = bus_wr && (bus_addr == OFS_COUNT);
  assign hit_irq   = bus_wr && (bus_addr == OFS_IRQ);

  always_comb begin
    ctrl_next  = masked_upd({dev_addr, 8'h00}, bus_wdata);
    count_next = masked_upd(16'(cmd_count), bus_wdata);
  end

  // enable only counts when its mask bit is set too
  assign start_req = hit_ctrl && bus_wdata[16] && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_addr  <= '0;
      cmd_count <= '0;
      done_q    <= 1'b0;
    end else begin
      if (hit_ctrl)  dev_addr  <= ctrl_next[15:8];
      if (hit_count) cmd_count <= count_next[IDX_W-1:0];
      if (seq_done)                      done_q <= 1'b1;
      else if (hit_irq && bus_wdata[1])  done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_cmd_buf.sv
module seq_cmd_buf #(
  parameter int DEPTH = 8,
  parameter int CMD_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CMD_W-1:0] wr_data,
  input  logic [IDX_W-1:0] bus_idx,
  output logic [CMD_W-1:0] bus_q,
  input  logic [IDX_W-1:0] seq_idx,
  output logic [CMD_W-1:0] seq_q
);
  logic [CMD_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                             slot[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))  slot[g] <= wr_data;
    end
  end

  assign bus_q = slot[bus_idx];
  assign seq_q = slot[seq_idx];
endmodule

// File: rtl/seq_engine.sv
module seq_engine #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [IDX_W-1:0] cmd_count,
  input  logic [7:0]       dev_addr,
  input  logic             cmd_ready,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] last_idx,
  output logic [7:0]       dev_lat,
  output logic             at_last,
  output logic             seq_done
);
  assign at_last  = busy && (idx == last_idx);
  assign seq_done = at_last && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      dev_lat  <= '0;
    end else if (!busy) begin
      if (start_req) begin
        busy     <= 1'b1;
        idx      <= '0;
        last_idx <= cmd_count;   // count and address frozen for the run
        dev_lat  <= dev_addr;
      end
    end else if (cmd_ready) begin
      if (idx == last_idx) busy <= 1'b0;
      else                 idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CMD_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [CMD_W-1:0] cmd_data,
  output logic [7:0]  cmd_dev,
  output logic        cmd_last
);
  logic [7:0]       dev_addr, dev_lat;
  logic [IDX_W-1:0] cmd_count, seq_idx, seq_last, buf_idx;
  logic             start_req, done_q, busy, at_last, seq_done, buf_hit;
  logic [CMD_W-1:0] buf_bus_q, buf_seq_q;

  assign buf_idx = bus_addr[IDX_W+1:2];
  assign buf_hit = (bus_addr[15:12] == BUF_PAGE) &&
                   (bus_addr[11:2] >> IDX_W) == '0 && bus_addr[1:0] == 2'b00;

  seq_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .seq_done(seq_done), .dev_addr(dev_addr),
    .cmd_count(cmd_count), .start_req(start_req), .done_q(done_q)
  );

  seq_cmd_buf #(.DEPTH(DEPTH), .CMD_W(CMD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && buf_hit), .wr_idx(buf_idx),
    .wr_data(bus_wdata[CMD_W-1:0]), .bus_idx(buf_idx), .bus_q(buf_bus_q),
    .seq_idx(seq_idx), .seq_q(buf_seq_q)
  );

  seq_engine #(.IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cmd_count(cmd_count),
    .dev_addr(dev_addr), .cmd_ready(cmd_ready), .busy(busy), .idx(seq_idx),
    .last_idx(seq_last), .dev_lat(dev_lat), .at_last(at_last), .seq_done(seq_done)
  );

  assign cmd_valid = busy;
  assign cmd_data  = buf_seq_q;
  assign cmd_dev   = dev_lat;
  assign cmd_last  = at_last;

  always_comb begin
    bus_rdata = '0;
    if (buf_hit) bus_rdata = 32'(buf_bus_q);
    else begin
      case (bus_addr)
        OFS_CTRL:   bus_rdata = {16'h0, dev_addr, 7'h0, busy};
        OFS_COUNT:  bus_rdata = 32'(cmd_count);
        OFS_STATUS: bus_rdata = {31'h0, busy};
        OFS_IRQ:    bus_rdata = {30'h0, done_q, 1'b0};
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_cmd_seq_chk.sv
module otp_cmd_seq_chk #(
  parameter int IDX_W = 3,
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [CMD_W-1:0] cmd_data,
  input logic [7:0]       cmd_dev,
  input logic             cmd_last,
  input logic             done_q,
  input logic [IDX_W-1:0] idx,
  input logic [IDX_W-1:0] last_idx
);
  // R1: reset clears the stream and the done flag
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !cmd_valid && !done_q);

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data) && $stable(cmd_dev) && $stable(cmd_last));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_last |=> !cmd_valid && done_q);

  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> idx <= last_idx);

  // R8: a running sequence neither stops early nor restarts
  a_r8_continue: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !(cmd_ready && cmd_last) |=> cmd_valid && idx >= $past(idx));
endmodule

bind otp_cmd_seq otp_cmd_seq_chk #(.IDX_W(IDX_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .cmd_dev(cmd_dev), .cmd_last(cmd_last),
  .done_q(done_q), .idx(seq_idx), .last_idx(seq_last)
);

// File: tb/otp_cmd_seq_test.sv
module otp_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmd_valid, cmd_ready = 1'b0, cmd_last;
  logic [7:0]  cmd_data, cmd_dev;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  otp_cmd_seq uut (.*);

  // macro port model: records every accepted byte
  logic [7:0] got [16];
  logic       got_last [16];
  int         ngot = 0;
  always @(posedge clk)
    if (rst_n && cmd_valid && cmd_ready) begin
      got[ngot % 16]      <= cmd_data;
      got_last[ngot % 16] <= cmd_last;
      ngot                <= ngot + 1;
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    foreach (uut.u_regs.dev_addr[i]) ; // no-op loop keeps structure simple
    rd(16'h0020, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(16'h0024, d); chk(d == 0, "R1 count", d, 0);
    rd(16'h002C, d); chk(d == 0, "R1 status", d, 0);
    rd(16'h0304, d); chk(d == 0, "R1 irq", d, 0);
    chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    wr(16'h0020, 32'hFF00AB00);
    rd(16'h0020, d); chk(d == 32'h0000AB00, "R2 dev write", d, 32'h0000AB00);
    wr(16'h0020, 32'h0000CD00);
    rd(16'h0020, d); chk(d == 32'h0000AB00, "R2 unmasked dev", d, 32'h0000AB00);
    wr(16'h0024, 32'h00070005);
    rd(16'h0024, d); chk(d == 5, "R2 count", d, 5);
    wr(16'h0024, 32'h00010002);
    rd(16'h0024, d); chk(d == 4, "R2 partial mask", d, 4);
  endtask

  task automatic t_buffer;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) wr(16'h1000 + 16'(4 * i), 32'hDEAD_BE00 | (32'h10 + i));
    for (int i = 0; i < 8; i++) begin
      rd(16'h1000 + 16'(4 * i), d);
      chk(d == 32'h10 + i, "R3 buffer word", d, 32'h10 + i);
    end
  endtask

  task automatic t_nomask;
    int base = ngot;
    wr(16'h0020, 32'h00000001);
    repeat (3) begin
      @(negedge clk);
      chk(cmd_valid == 0, "R9 no start without mask", cmd_valid, 0);
    end
    chk(ngot == base, "R9 no bytes", ngot - base, 0);
  endtask

  task automatic t_ecc_seq;
    logic [31:0] d;
    int base;
    wr(16'h1000, 32'hFA); wr(16'h1004, 32'h09);
    wr(16'h0024, 32'h00070001);
    wr(16'h0020, 32'hFF000200);
    cmd_ready = 1'b1; base = ngot;
    wr(16'h0020, 32'h00010001);
    chk(cmd_valid && cmd_data == 8'hFA && cmd_dev == 8'h02 && !cmd_last, "R4 first byte",
        {cmd_valid, cmd_last, cmd_dev, cmd_data}, {2'b10, 8'h02, 8'hFA});
    @(negedge clk);
    chk(cmd_valid && cmd_data == 8'h09 && cmd_last, "R4 last byte",
        {cmd_valid, cmd_last, cmd_data}, {2'b11, 8'h09});
    @(negedge clk);
    chk(!cmd_valid, "R6 stream ends", cmd_valid, 0);
    rd(16'h002C, d); chk(d == 0, "R6 busy clear", d, 0);
    rd(16'h0020, d); chk(d == 32'h0200, "R6 enable self-clears", d, 32'h0200);
    rd(16'h0304, d); chk(d == 2, "R6 done flag", d, 2);
    chk(ngot - base == 2 && got[base % 16] == 8'hFA && got[(base + 1) % 16] == 8'h09 &&
        got_last[(base + 1) % 16], "R4 bytes received", ngot - base, 2);
  endtask

  task automatic t_done_clear;
    logic [31:0] d;
    wr(16'h0304, 32'h0);
    rd(16'h0304, d); chk(d == 2, "R7 write 0 keeps", d, 2);
    wr(16'h0304, 32'h2);
    rd(16'h0304, d); chk(d == 0, "R7 write 1 clears", d, 0);
  endtask

  task automatic t_backpressure;
    int base, cyc;
    wr(16'h1000, 32'h11); wr(16'h1004, 32'h22); wr(16'h1008, 32'h33); wr(16'h100C, 32'h44);
    wr(16'h0024, 32'h00070003);
    cmd_ready = 1'b0; base = ngot;
    wr(16'h0020, 32'h00010001);
    repeat (3) begin
      @(negedge clk);
      chk(cmd_valid && cmd_data == 8'h11 && !cmd_last, "R5 hold under back-pressure",
          {cmd_valid, cmd_data}, {1'b1, 8'h11});
    end
    cmd_ready = 1'b1; cyc = 0;
    while (cmd_valid && cyc < 20) begin @(negedge clk); cyc++; end
    chk(cyc == 4, "R4 count+1 cycles", cyc, 4);
    chk(ngot - base == 4, "R4 four bytes", ngot - base, 4);
    for (int i = 0; i < 4; i++)
      chk(got[(base + i) % 16] == 8'h11 * (i + 1), "R4 byte order", got[(base + i) % 16], 8'h11 * (i + 1));
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d;
    int base;
    wr(16'h0024, 32'h00070001);
    cmd_ready = 1'b0; base = ngot;
    wr(16'h0020, 32'h00010001);
    wr(16'h0020, 32'h00010001);
    chk(cmd_valid && cmd_data == 8'h11, "R8 still on first byte", cmd_data, 8'h11);
    cmd_ready = 1'b1;
    repeat (2) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(!cmd_valid, "R8 no restart", cmd_valid, 0);
    end
    chk(ngot - base == 2, "R8 two bytes only", ngot - base, 2);
    rd(16'h0304, d); chk(d == 2, "R6 done after run", d, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_buffer();
    t_nomask();
    t_ecc_seq();
    t_done_clear();
    t_backpressure();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule